// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Controller

This block is the digital side of a successive-approximation analog-to-digital converter that runs one-shot conversions. Software writes a byte-wide control/status register to pick an input channel and a step speed, optionally enable the interrupt, and set the start bit. The controller then holds a sample period and performs a ten-step binary search. It drives a trial code to an external DAC and reads back one comparator bit per step, starting with the most significant bit. The analog sample-and-hold, the DAC and the comparator are outside the block. They are represented by the `sample_en` and `dac_code` outputs and the `cmp_in` input.

When the search ends, the ten-bit answer is stored left-justified in a 16-bit result entry for the selected channel. The start bit drops, a completion flag rises, and an interrupt request follows the flag whenever the interrupt enable is set. A transfer-controller acknowledge clears the flag on its own. Software can also clear it, but only by reading the status register while the flag is up and then writing zero to the flag bit. The start bit doubles as the busy indicator, and writing it back to zero aborts a conversion.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A conversion resolves ten bits most significant first; with `cmp_in` high whenever the analog level is at or above `dac_code`, the stored code equals that level (0 to 1023).
- R2: The result appears as a 16-bit value with the code in bits 15:6 and bits 5:0 zero (0x0000 to 0xFFC0). It is stored in the entry of the channel selected at start, and a `res_rd` pulse returns the entry named by `res_ch` on `res_rdata` one cycle later.
- R3: Writing 1 to register bit 5 while idle starts a conversion. Bit 5 reads 1 for the whole conversion, and hardware clears it at completion.
- R4: Register bit 3 picks the step length: 0 gives 8 clocks, 1 gives 4 clocks. A sample period of one step length precedes the ten steps, so completion lands 88 (slow) or 44 (fast) clock edges after the starting write edge.
- R5: Completion sets the flag in register bit 7.
- R6: `irq` is high exactly when the flag (bit 7) and the interrupt enable (bit 6) are both 1.
- R7: A `xfer_ack` pulse clears the flag.
- R8: Writing 0 to bit 7 clears the flag only if a register read returned the flag as 1 in an earlier cycle. Otherwise the flag stays 1.
- R9: Writing 1 to bit 7 never sets or keeps-alive the flag; such a write leaves it as it was.
- R10: While bit 5 is 1, writes to the channel field (bits 2:0) and to bit 3 are ignored, while bit 6 still takes the written value.
- R11: Writing 0 to bit 5 during a conversion stops it. The flag is not set and the channel's stored result keeps its old value.
- R12: A `csr_rd` pulse returns {flag, enable, start, 0, clock select, channel} on `csr_rdata` one cycle later. Bit 4 (multi-channel mode) always reads 0 and has no effect, and a single write of 0x61 starts channel 1 with the interrupt enabled and slow steps.
- R13: If completion and a flag-clearing event fall in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Control/status register write strobe |
| csr_rd | input | 1 | Control/status register read strobe |
| csr_wdata | input | 8 | Write data for the control/status register |
| csr_rdata | output | 8 | Registered read data of the control/status register |
| xfer_ack | input | 1 | Transfer-controller service acknowledge, clears the flag |
| res_rd | input | 1 | Result read strobe |
| res_ch | input | CH_W | Channel whose result is read |
| res_rdata | output | RES_W | Registered left-justified result |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the trial code |
| dac_code | output | RES_BITS | Trial code for the external DAC |
| sample_en | output | 1 | High during the sample period |
| irq | output | 1 | End-of-conversion interrupt request |

## Verification
The hazard of interest is the flag being set by the final approximation step in the very cycle that something tries to clear it. The bench counts edges from the starting write, which fast-mode timing makes exact. It then holds `xfer_ack` high for exactly the completing edge and expects both the flag and `irq` to survive. A second overlap, an abort write against the running step sequence, is judged by checking that the start bit, the flag and the channel's stored result all keep their non-completed values long after the conversion would have ended.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  // Bit positions inside the control/status byte; the software view depends on them.
  localparam int CSR_FLAG  = 7;
  localparam int CSR_IE    = 6;
  localparam int CSR_START = 5;
  localparam int CSR_SCAN  = 4;
  localparam int CSR_CKS   = 3;
  localparam int CSR_CH_W  = 3;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } sar_state_e;

endpackage

// File: rtl/sar_csr.sv
module sar_csr
  import sar_adc_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [7:0]      wdata_i,
  input  logic            done_i,
  input  logic            ack_i,
  output logic [7:0]      rdata_o,
  output logic            flag_o,
  output logic            ie_o,
  output logic            start_o,
  output logic            fast_o,
  output logic [CH_W-1:0] ch_o,
  output logic            launch_o,
  output logic            abort_o,
  output logic            irq_o
);

  logic            flag_q, flag_n;
  logic            armed_q, armed_n;
  logic            ie_q, ie_n;
  logic            start_q, start_n;
  logic            fast_q;
  logic [CH_W-1:0] ch_q;
  logic [2:0]      ch_field;
  logic            scan_req_unused;

  // Multi-channel mode is not built; its request bit is accepted and dropped.
  assign scan_req_unused = wdata_i[CSR_SCAN];

  assign launch_o = wr_i && !start_q && wdata_i[CSR_START];
  assign abort_o  = wr_i && start_q && !wdata_i[CSR_START];

  always_comb begin
    flag_n  = flag_q;
    armed_n = armed_q;
    ie_n    = wr_i ? wdata_i[CSR_IE] : ie_q;
    start_n = start_q;
    if (rd_i && flag_q) armed_n = 1'b1;
    // A zero written to the flag only counts after the flag was seen by a read.
    if (wr_i && !wdata_i[CSR_FLAG] && armed_q) begin
      flag_n  = 1'b0;
      armed_n = 1'b0;
    end
    if (ack_i) begin
      flag_n  = 1'b0;
      armed_n = 1'b0;
    end
    if (launch_o) start_n = 1'b1;
    if (abort_o)  start_n = 1'b0;
    // Completion has the last word: a fresh result must be reported.
    if (done_i) begin
      flag_n  = 1'b1;
      armed_n = 1'b0;
      start_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      ie_q    <= 1'b0;
      start_q <= 1'b0;
      fast_q  <= 1'b0;
      ch_q    <= '0;
      irq_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      flag_q  <= flag_n;
      armed_q <= armed_n;
      ie_q    <= ie_n;
      start_q <= start_n;
      irq_o   <= flag_n && ie_n;
      if (wr_i && !start_q) begin
        fast_q <= wdata_i[CSR_CKS];
        ch_q   <= wdata_i[CH_W-1:0];
      end
      if (rd_i) begin
        rdata_o <= {flag_q, ie_q, start_q, 1'b0, fast_q, ch_field};
      end
    end
  end

  always_comb begin
    ch_field           = '0;
    ch_field[CH_W-1:0] = ch_q;
  end

  assign flag_o  = flag_q;
  assign ie_o    = ie_q;
  assign start_o = start_q;
  assign fast_o  = fast_q;
  assign ch_o    = ch_q;

  // R8: the flag only rises on a completion, never through a write.
  a_r8_flag_rise_from_done: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(done_i));

  // R7: an acknowledge without a coincident completion drops the flag.
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ack_i && !done_i |=> !flag_q);

  // R8: without a prior read and without an acknowledge the flag holds.
  a_r8_unread_flag_holds: assert property (@(posedge clk) disable iff (rst)
    flag_q && !armed_q && !ack_i |=> flag_q);

  // R10: channel and speed are frozen while a conversion runs.
  a_r10_fields_frozen: assert property (@(posedge clk) disable iff (rst)
    start_q |=> $stable(ch_q) && $stable(fast_q));

  // R3: completion drops the start bit.
  a_r3_done_clears_start: assert property (@(posedge clk) disable iff (rst)
    done_i |=> !start_q);

endmodule

// File: rtl/sar_timer.sv
module sar_timer #(
  parameter int SLOW_DIV = 8,
  parameter int FAST_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic fast_i,
  output logic tick_o
);

  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last   = fast_i ? FAST_LAST : SLOW_LAST;
  assign tick_o = run_i && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: the step counter never passes the selected period.
  a_r4_count_in_period: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last);

  // R4: counting restarts from zero whenever the converter is idle.
  a_r4_idle_count_zero: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> cnt_q == '0);

endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                launch_i,
  input  logic                abort_i,
  input  logic                tick_i,
  input  logic                cmp_i,
  output logic                busy_o,
  output logic                sample_o,
  output logic                done_o,
  output logic [RES_BITS-1:0] code_o,
  output logic [RES_BITS-1:0] dac_o
);

  localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

  sar_state_e          state_q;
  logic [RES_BITS-1:0] acc_q;
  logic [RES_BITS-1:0] mask_q;
  logic [RES_BITS-1:0] decided;

  // Keep the trial bit only when the input is at or above the trial level.
  assign decided  = cmp_i ? (acc_q | mask_q) : acc_q;
  assign done_o   = (state_q == ST_CONVERT) && tick_i && mask_q[0] && !abort_i;
  assign code_o   = decided;
  assign dac_o    = acc_q | mask_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign sample_o = (state_q == ST_SAMPLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      acc_q   <= '0;
      mask_q  <= '0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
    end else if (launch_i) begin
      state_q <= ST_SAMPLE;
      acc_q   <= '0;
      mask_q  <= '0;
    end else if (tick_i) begin
      case (state_q)
        ST_SAMPLE: begin
          state_q <= ST_CONVERT;
          mask_q  <= TOP_BIT;
        end
        ST_CONVERT: begin
          acc_q  <= decided;
          mask_q <= mask_q >> 1;
          if (mask_q[0]) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: exactly one trial bit is under test at any time.
  a_r1_single_trial_bit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask_q));

  // R1: every converting cycle has a bit under test.
  a_r1_convert_has_trial: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONVERT) |-> (mask_q != '0));

  // R1: bits below the trial bit are still zero during the search.
  a_r1_lower_bits_clear: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONVERT) |-> ((acc_q & (mask_q | (mask_q - 1'b1))) == '0));

  // R11: an abort returns the engine to idle.
  a_r11_abort_idles: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> state_q == ST_IDLE);

endmodule

// File: rtl/sar_result_ram.sv
module sar_result_ram #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 10,
  parameter int OUT_W  = 16
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [CH_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic             re_i,
  input  logic [CH_W-1:0]  raddr_i,
  output logic [OUT_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << CH_W;
  localparam int PAD_W = OUT_W - DATA_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rd_q <= mem[raddr_i];
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata_o = {rd_q, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign rdata_o = rd_q;
    end
  endgenerate

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int RES_BITS = 10,
  parameter int RES_W    = 16,
  parameter int CH_W     = 3,
  parameter int SLOW_DIV = 8,
  parameter int FAST_DIV = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                csr_wr,
  input  logic                csr_rd,
  input  logic [7:0]          csr_wdata,
  output logic [7:0]          csr_rdata,
  input  logic                xfer_ack,
  input  logic                res_rd,
  input  logic [CH_W-1:0]     res_ch,
  output logic [RES_W-1:0]    res_rdata,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] dac_code,
  output logic                sample_en,
  output logic                irq
);

  logic                flag, ie, start, fast, launch, abort, done, busy, tick;
  logic [CH_W-1:0]     ch;
  logic [RES_BITS-1:0] code;

  sar_csr #(.CH_W(CH_W)) u_csr (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (csr_wr),
    .rd_i     (csr_rd),
    .wdata_i  (csr_wdata),
    .done_i   (done),
    .ack_i    (xfer_ack),
    .rdata_o  (csr_rdata),
    .flag_o   (flag),
    .ie_o     (ie),
    .start_o  (start),
    .fast_o   (fast),
    .ch_o     (ch),
    .launch_o (launch),
    .abort_o  (abort),
    .irq_o    (irq)
  );

  sar_timer #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run_i  (busy),
    .fast_i (fast),
    .tick_o (tick)
  );

  sar_engine #(.RES_BITS(RES_BITS)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .launch_i (launch),
    .abort_i  (abort),
    .tick_i   (tick),
    .cmp_i    (cmp_in),
    .busy_o   (busy),
    .sample_o (sample_en),
    .done_o   (done),
    .code_o   (code),
    .dac_o    (dac_code)
  );

  sar_result_ram #(.CH_W(CH_W), .DATA_W(RES_BITS), .OUT_W(RES_W)) u_ram (
    .clk     (clk),
    .we_i    (done),
    .waddr_i (ch),
    .wdata_i (code),
    .re_i    (res_rd),
    .raddr_i (res_ch),
    .rdata_o (res_rdata)
  );

  // R6: the request follows flag and enable together.
  a_r6_irq_follows_flag: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && ie));

  // R3: the start bit and the engine's activity agree in every cycle.
  a_r3_start_is_busy: assert property (@(posedge clk) disable iff (rst)
    start == busy);

  // R5: a completion is followed by a raised flag.
  a_r5_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
    done |=> flag);

endmodule

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int RES_BITS   = 10;
  localparam int RES_W      = 16;
  localparam int CH_W       = 3;

  logic                clk = 1'b0;
  logic                rst;
  logic                csr_wr, csr_rd, xfer_ack, res_rd;
  logic [7:0]          csr_wdata;
  logic [7:0]          csr_rdata;
  logic [CH_W-1:0]     res_ch;
  logic [RES_W-1:0]    res_rdata;
  logic [RES_BITS-1:0] dac_code;
  logic                sample_en, irq, cmp_in;
  logic [RES_BITS-1:0] vin;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [RES_W-1:0] exp_res [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  // Ideal comparator: high when the input is at or above the trial code.
  assign cmp_in = (vin >= dac_code);

  sar_adc_ctrl i_sar_adc_ctrl (
    .clk       (clk),
    .rst       (rst),
    .csr_wr    (csr_wr),
    .csr_rd    (csr_rd),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .xfer_ack  (xfer_ack),
    .res_rd    (res_rd),
    .res_ch    (res_ch),
    .res_rdata (res_rdata),
    .cmp_in    (cmp_in),
    .dac_code  (dac_code),
    .sample_en (sample_en),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [7:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = d;
    @(posedge clk);
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic csr_read(output logic [7:0] d);
    @(negedge clk);
    csr_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    csr_rd = 1'b0;
    d = csr_rdata;
  endtask

  task automatic res_read(input int ch, output logic [RES_W-1:0] d);
    @(negedge clk);
    res_rd = 1'b1; res_ch = CH_W'(ch);
    @(posedge clk);
    @(negedge clk);
    res_rd = 1'b0;
    d = res_rdata;
  endtask

  task automatic ack_pulse();
    @(negedge clk);
    xfer_ack = 1'b1;
    @(negedge clk);
    xfer_ack = 1'b0;
  endtask

  // Starts with a write (interrupt enabled) and counts edges until irq is seen.
  task automatic run_conv(input logic [7:0] d, output int cyc);
    csr_write(d);
    cyc = 0;
    while (!irq && cyc < 400) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0]       r;
    logic [RES_W-1:0] q;
    int               cyc;
    rst = 1'b1; csr_wr = 0; csr_rd = 0; csr_wdata = '0; xfer_ack = 0;
    res_rd = 0; res_ch = '0; vin = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // Reset state.
    chk("R12 reset irq", 32'(irq), 0);
    chk("R1 reset dac", 32'(dac_code), 0);
    csr_read(r);
    chk("R12 reset csr", 32'(r), 0);

    // R12: bit 4 reads zero and does not start anything.
    csr_write(8'h13);
    csr_read(r);
    chk("R12 scan bit reads 0", 32'(r), 32'h03);
    idle(20);
    chk("R12 scan bit inert", 32'(irq), 0);

    // R1 R2 R4 R7: every code, fast steps, channel rotating.
    for (int v = 0; v < 1024; v++) begin
      int ch;
      ch  = v % 8;
      vin = RES_BITS'(v);
      run_conv(8'h68 | 8'(ch), cyc);
      chk("R4 fast timing", 32'(cyc), 44);
      ack_pulse();
      if (v == 0) chk("R7 ack clears irq", 32'(irq), 0);
      res_read(ch, q);
      chk("R1 R2 result", 32'(q), 32'(v) << 6);
      exp_res[ch] = RES_W'(v) << 6;
    end
    csr_read(r);
    chk("R7 ack clears flag", 32'(r), 32'h4F);

    // R4 R12: slow steps with the single-write start value 0x61.
    vin = 10'h3FF;
    csr_write(8'h61);
    csr_read(r);
    chk("R3 R12 start reads 1 during conversion", 32'(r), 32'h61);
    cyc = 2;
    while (!irq && cyc < 400) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    chk("R4 slow timing", 32'(cyc), 88);
    res_read(1, q);
    chk("R2 full scale", 32'(q), 32'hFFC0);
    exp_res[1] = 16'hFFC0;

    // R5 R6 R8 R9: flag clearing rules, flag up from the slow run.
    csr_write(8'h41);
    csr_read(r);
    chk("R8 unread zero keeps flag", 32'(r), 32'hC1);
    chk("R6 irq still high", 32'(irq), 1);
    csr_write(8'hC1);
    csr_read(r);
    chk("R9 write 1 leaves flag", 32'(r), 32'hC1);
    csr_write(8'h41);
    csr_read(r);
    chk("R8 read then zero clears", 32'(r), 32'h41);
    chk("R6 irq low after clear", 32'(irq), 0);
    csr_write(8'h81);
    csr_read(r);
    chk("R9 write 1 does not set", 32'(r), 32'h01);

    // R10 R6: fields frozen while running, enable still writable.
    vin = 10'h0AB;
    csr_write(8'h63);
    idle(5);
    csr_write(8'h6D);
    csr_read(r);
    chk("R10 channel and speed frozen", 32'(r), 32'h63);
    csr_write(8'h2D);
    csr_read(r);
    chk("R10 enable writable", 32'(r), 32'h23);
    idle(100);
    chk("R6 no irq with enable off", 32'(irq), 0);
    csr_read(r);
    chk("R5 flag set, start cleared", 32'(r), 32'h83);
    res_read(3, q);
    chk("R2 result in started channel", 32'(q), 32'h0AB << 6);
    res_read(5, q);
    chk("R10 other channel untouched", 32'(q), 32'(exp_res[5]));
    csr_write(8'h03);
    csr_read(r);
    chk("R8 clear after read", 32'(r), 32'h03);

    // R11: abort leaves flag and stored result alone.
    vin = 10'h155;
    csr_write(8'h62);
    idle(20);
    csr_write(8'h42);
    csr_read(r);
    chk("R11 start cleared by abort", 32'(r), 32'h42);
    idle(100);
    chk("R11 no irq after abort", 32'(irq), 0);
    csr_read(r);
    chk("R11 no flag after abort", 32'(r), 32'h42);
    res_read(2, q);
    chk("R11 result unchanged", 32'(q), 32'(exp_res[2]));

    // R13: acknowledge lands on the completing edge.
    vin = 10'h2A5;
    csr_write(8'h6C);
    repeat (43) @(negedge clk);
    xfer_ack = 1'b1;
    @(negedge clk);
    xfer_ack = 1'b0;
    chk("R13 irq survives coincident ack", 32'(irq), 1);
    csr_read(r);
    chk("R13 flag survives coincident ack", 32'(r), 32'hCC);
    res_read(4, q);
    chk("R1 result mid-scale", 32'(q), 32'h2A5 << 6);
    ack_pulse();
    chk("R7 ack after overlap", 32'(irq), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule